// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block steps a flash array through the programming of one page at a time. It is driven by control-register writes. Software first raises a program-mode bit. The first accepted data write after that is the interlock write: it latches the page address and the target space, normal or shadow. Further data writes that fall in the same page fill a page buffer. Software then raises a high-voltage enable bit, which starts a timed program engine. When the engine finishes, a done flag rises and a pass flag reports the engine's verdict.

The high-voltage enable bit is both the start control and the abort control. Clearing it while the engine runs aborts the page, unless a program suspend is in force. Clearing it after done returns the block to waiting for a new interlock, with program mode still set. Clearing program mode before the start ends the sequence and programs nothing.

The array is modelled as a small word store with one valid bit per word, plus a combinational read port. Every word reads as all ones at reset. A page whose programming fails or is aborted is marked invalid, so its contents count as undefined.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, st_mode, st_hv, st_pass, st_armed and st_shadow are 0 and st_done is 1. Every array word reads 0xFFFFFFFF with rd_valid high.
- R2: A control write with ctl_mode=1 from the idle state sets st_mode. The next data write that is aligned and unlocked is the interlock write: it sets st_armed and latches the page and space. Data writes made while program mode is off are ignored. The address is a word address with bit 4 as the space (1 = shadow), bits 3:2 as the page and bits 1:0 as the word.
- R3: Once the interlock is done, data writes in the latched page load page-buffer words. Any word never written is programmed as 0xFFFFFFFF.
- R4: Repeated writes to one word keep only the last data. A doubleword write (arr_dw=1) puts arr_wdata[31:0] at the even word and arr_wdata[63:32] at the word after it. A doubleword write to an odd word is ignored.
- R5: Once the interlock is done, data writes to any other page or space are ignored.
- R6: A control write with ctl_hv=1 before an interlock write leaves st_hv at 0 and st_done unchanged.
- R7: A control write with ctl_mode=0 before the start returns the block to idle (st_mode=0, st_armed=0) and leaves the array unchanged.
- R8: Lock bit b of lock_mask covers normal-space pages b*BLOCK_PAGES to (b+1)*BLOCK_PAGES-1. Bit NUM_BLOCKS covers the shadow space. An interlock write to a locked page is ignored and st_armed stays 0.
- R9: A start write (ctl_mode=1, ctl_hv=1) after the interlock clears st_done at that clock edge and sets st_hv. st_done rises PROG_CYCLES unsuspended edges later, and st_pass then equals eng_pass. On pass the page takes the buffered data; on fail its words become invalid.
- R10: After done, a control write with ctl_mode=1 and ctl_hv=0 clears st_hv and st_armed, keeps st_mode, st_done and st_pass, and accepts a new interlock.
- R11: While programming runs with prog_susp low, a control write with ctl_hv=0 aborts at that edge. st_done goes to 1, st_pass and st_hv go to 0, and the page words become invalid.
- R12: While prog_susp is high, ctl_hv=0 writes do not abort and the engine count holds.
- R13: When erase_susp is low, an interlock write sets st_shadow to its space bit. When erase_susp is high, st_shadow keeps its value.
- R14: While programming runs, the ctl_mode value of a control write is ignored and st_mode stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_mode | input | 1 | Program-mode value written |
| ctl_hv | input | 1 | High-voltage enable value written |
| arr_wr | input | 1 | Array-space data write strobe |
| arr_dw | input | 1 | Data write is a doubleword |
| arr_addr | input | AW (5) | Word address: space, page, word |
| arr_wdata | input | 2*WORD_W (64) | Write data, low word first |
| lock_mask | input | NUM_BLOCKS+1 (3) | Per-block lock bits, top bit shadow |
| prog_susp | input | 1 | Program suspend in force |
| erase_susp | input | 1 | Program runs inside an erase suspend |
| eng_pass | input | 1 | Program engine verdict |
| rd_addr | input | AW (5) | Array read address |
| st_mode | output | 1 | Program mode active |
| st_hv | output | 1 | High-voltage enable active |
| st_done | output | 1 | Operation complete |
| st_pass | output | 1 | Last program succeeded |
| st_armed | output | 1 | Page latched by interlock write |
| st_shadow | output | 1 | Space-select status |
| rd_data | output | WORD_W (32) | Array read data |
| rd_valid | output | 1 | Array word holds defined data |

## Verification
Control and data writes take effect at the clock edge that captures them, so every flag is due one edge after the write. The one exception is st_done: it rises exactly PROG_CYCLES counted edges after the start edge, and edges under suspend do not count. The bench drives each write for one cycle starting at a falling edge and samples the flags at the next falling edge. It checks st_done both one edge before and exactly at the edge where it is due. Array reads are combinational, so they are checked a short delay after the address changes while the block is quiet.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

   typedef enum logic [2:0] {
      FS_IDLE    = 3'd0,
      FS_WAIT_IL = 3'd1,
      FS_LOADED  = 3'd2,
      FS_PROG    = 3'd3,
      FS_DONE    = 3'd4
   } fpp_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fpp_lock.sv
module fpp_lock #(
   parameter int NUM_PAGES   = 4,
   parameter int BLOCK_PAGES = 2,
   parameter bit SHADOW_LOCK = 1'b1,
   localparam int PG_W       = $clog2(NUM_PAGES),
   localparam int NUM_BLOCKS = NUM_PAGES / BLOCK_PAGES
) (
   input  logic [PG_W-1:0]     page,
   input  logic                space,
   input  logic [NUM_BLOCKS:0] lock_vec,
   output logic                locked
);

   logic [NUM_PAGES-1:0] page_lock;
   logic                 shadow_lock;

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      assign page_lock[p] = lock_vec[p / BLOCK_PAGES];
   end

   if (SHADOW_LOCK) begin : g_shadow_lock
      assign shadow_lock = lock_vec[NUM_BLOCKS];
   end else begin : g_shadow_free
      assign shadow_lock = 1'b0;
   end

   assign locked = space ? shadow_lock : page_lock[page];

endmodule

// File: rtl/fpp_pgbuf.sv
module fpp_pgbuf #(
   parameter int WORD_W     = 32,
   parameter int PAGE_WORDS = 4,
   localparam int WD_W      = $clog2(PAGE_WORDS)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clr,
   input  logic                                 wr,
   input  logic                                 dw,
   input  logic [WD_W-1:0]                      idx,
   input  logic [2*WORD_W-1:0]                  wdata,
   output logic [PAGE_WORDS-1:0][WORD_W-1:0]    words
);

   for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
      logic hit_lo;
      logic hit_hi;

      assign hit_lo = wr && (idx == WD_W'(i));

      if (i % 2 == 1) begin : g_odd
         assign hit_hi = wr && dw && (idx == WD_W'(i - 1));
      end else begin : g_even
         assign hit_hi = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[i] <= '1;
         end else if (clr) begin
            words[i] <= '1;
         end else if (hit_lo) begin
            words[i] <= wdata[WORD_W-1:0];
         end else if (hit_hi) begin
            words[i] <= wdata[2*WORD_W-1:WORD_W];
         end
      end
   end

   // R3: a cleared buffer holds only erased words
   a_r3_clear_fill: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (words == '1));

endmodule

// File: rtl/fpp_timer.sv
module fpp_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expire
);

   if (CYCLES == 1) begin : g_single
      assign expire = run;
   end else begin : g_count
      localparam int CW = $clog2(CYCLES);
      logic [CW-1:0] cnt;

      assign expire = run && (cnt == CW'(CYCLES - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (start) begin
            cnt <= '0;
         end else if (run) begin
            cnt <= expire ? '0 : cnt + 1'b1;
         end
      end

      // R9: completion is a single-cycle event
      a_r9_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
         expire |=> !expire);

      // R12: a paused count does not move
      a_r12_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!run && !start) |=> $stable(cnt));
   end

endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
   parameter int WORD_W     = 32,
   parameter int NUM_PAGES  = 4,
   parameter int PAGE_WORDS = 4,
   localparam int WD_W      = $clog2(PAGE_WORDS),
   localparam int NSEL      = 2 * NUM_PAGES,
   localparam int SEL_W     = $clog2(NSEL),
   localparam int AW        = SEL_W + WD_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               commit,
   input  logic                               trash,
   input  logic [SEL_W-1:0]                   sel,
   input  logic [PAGE_WORDS-1:0][WORD_W-1:0]  words,
   input  logic [AW-1:0]                      rd_addr,
   output logic [WORD_W-1:0]                  rd_data,
   output logic                               rd_valid
);

   logic [NSEL-1:0][PAGE_WORDS-1:0][WORD_W-1:0] all_mem;
   logic [NSEL-1:0][PAGE_WORDS-1:0]             all_vld;

   for (genvar p = 0; p < NSEL; p++) begin : g_page
      logic [PAGE_WORDS-1:0][WORD_W-1:0] pmem;
      logic [PAGE_WORDS-1:0]             pvld;
      logic                              hit;

      assign hit = (sel == SEL_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pmem <= '1;
            pvld <= '1;
         end else if (hit && commit) begin
            pmem <= words;
            pvld <= '1;
         end else if (hit && trash) begin
            pvld <= '0;
         end
      end

      assign all_mem[p] = pmem;
      assign all_vld[p] = pvld;
   end

   assign rd_data  = all_mem[rd_addr[AW-1:WD_W]][rd_addr[WD_W-1:0]];
   assign rd_valid = all_vld[rd_addr[AW-1:WD_W]][rd_addr[WD_W-1:0]];

   // R9: a page is either written or invalidated, never both
   a_r9_commit_xor_trash: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && trash));

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
   import fpp_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int NUM_PAGES   = 4,
   parameter int PAGE_WORDS  = 4,
   parameter int BLOCK_PAGES = 2,
   parameter int PROG_CYCLES = 8,
   parameter bit SHADOW_LOCK = 1'b1,
   localparam int PG_W       = $clog2(NUM_PAGES),
   localparam int WD_W       = $clog2(PAGE_WORDS),
   localparam int AW         = 1 + PG_W + WD_W,
   localparam int NUM_BLOCKS = NUM_PAGES / BLOCK_PAGES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_wr,
   input  logic                  ctl_mode,
   input  logic                  ctl_hv,
   input  logic                  arr_wr,
   input  logic                  arr_dw,
   input  logic [AW-1:0]         arr_addr,
   input  logic [2*WORD_W-1:0]   arr_wdata,
   input  logic [NUM_BLOCKS:0]   lock_mask,
   input  logic                  prog_susp,
   input  logic                  erase_susp,
   input  logic                  eng_pass,
   input  logic [AW-1:0]         rd_addr,
   output logic                  st_mode,
   output logic                  st_hv,
   output logic                  st_done,
   output logic                  st_pass,
   output logic                  st_armed,
   output logic                  st_shadow,
   output logic [WORD_W-1:0]     rd_data,
   output logic                  rd_valid
);

   if (!is_pow2(NUM_PAGES) || NUM_PAGES < 2) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two, at least 2");
   end
   if (!is_pow2(PAGE_WORDS) || PAGE_WORDS < 2) begin : g_bad_words
      $error("PAGE_WORDS must be a power of two, at least 2");
   end
   if (!is_pow2(BLOCK_PAGES) || BLOCK_PAGES > NUM_PAGES) begin : g_bad_block
      $error("BLOCK_PAGES must be a power of two no larger than NUM_PAGES");
   end
   if (PROG_CYCLES < 1) begin : g_bad_cycles
      $error("PROG_CYCLES must be at least 1");
   end

   fpp_state_e        state;
   logic [PG_W-1:0]   pg_q;
   logic              sp_q;
   logic              shadow_q;
   logic              done_q;
   logic              pass_q;

   logic              a_space;
   logic [PG_W-1:0]   a_page;
   logic [WD_W-1:0]   a_word;
   logic              blk_locked;
   logic              aligned;
   logic              il_ok;
   logic              ld_ok;
   logic              start_seq;
   logic              rearm;
   logic              hv_go;
   logic              abort;
   logic              expire;
   logic              run;
   logic              finish;
   logic              buf_clr;
   logic [PAGE_WORDS-1:0][WORD_W-1:0] buf_words;

   // address split: space, page, word
   assign a_space = arr_addr[AW-1];
   assign a_page  = arr_addr[AW-2 -: PG_W];
   assign a_word  = arr_addr[WD_W-1:0];
   assign aligned = !arr_dw || !a_word[0];

   fpp_lock #(
      .NUM_PAGES   (NUM_PAGES),
      .BLOCK_PAGES (BLOCK_PAGES),
      .SHADOW_LOCK (SHADOW_LOCK)
   ) u_lock (
      .page     (a_page),
      .space    (a_space),
      .lock_vec (lock_mask),
      .locked   (blk_locked)
   );

   assign il_ok     = arr_wr && (state == FS_WAIT_IL) && !blk_locked && aligned;
   assign ld_ok     = arr_wr && (state == FS_LOADED) && !blk_locked && aligned &&
                      (a_space == sp_q) && (a_page == pg_q);
   assign start_seq = ctl_wr && ctl_mode && (state == FS_IDLE);
   assign rearm     = ctl_wr && !ctl_hv && ctl_mode && (state == FS_DONE);
   assign hv_go     = ctl_wr && ctl_hv && ctl_mode && (state == FS_LOADED);
   assign abort     = ctl_wr && !ctl_hv && !prog_susp && (state == FS_PROG);
   assign run       = (state == FS_PROG) && !prog_susp;
   assign finish    = expire && !abort;
   assign buf_clr   = start_seq || rearm || abort;

   fpp_pgbuf #(
      .WORD_W     (WORD_W),
      .PAGE_WORDS (PAGE_WORDS)
   ) u_pgbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (buf_clr),
      .wr    (il_ok || ld_ok),
      .dw    (arr_dw),
      .idx   (a_word),
      .wdata (arr_wdata),
      .words (buf_words)
   );

   fpp_timer #(
      .CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (hv_go),
      .run    (run),
      .expire (expire)
   );

   fpp_array #(
      .WORD_W     (WORD_W),
      .NUM_PAGES  (NUM_PAGES),
      .PAGE_WORDS (PAGE_WORDS)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (finish && eng_pass),
      .trash    (abort || (finish && !eng_pass)),
      .sel      ({sp_q, pg_q}),
      .words    (buf_words),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_IDLE;
         pg_q     <= '0;
         sp_q     <= 1'b0;
         shadow_q <= 1'b0;
         done_q   <= 1'b1;
         pass_q   <= 1'b0;
      end else begin
         unique case (state)
            FS_IDLE: begin
               if (start_seq) state <= FS_WAIT_IL;
            end
            FS_WAIT_IL: begin
               if (ctl_wr && !ctl_mode) begin
                  state <= FS_IDLE;
               end else if (il_ok) begin
                  state <= FS_LOADED;
                  pg_q  <= a_page;
                  sp_q  <= a_space;
                  if (!erase_susp) shadow_q <= a_space;
               end
            end
            FS_LOADED: begin
               if (ctl_wr && !ctl_mode) begin
                  state <= FS_IDLE;
               end else if (hv_go) begin
                  state  <= FS_PROG;
                  done_q <= 1'b0;
               end
            end
            FS_PROG: begin
               if (abort) begin
                  state  <= FS_WAIT_IL;
                  done_q <= 1'b1;
                  pass_q <= 1'b0;
               end else if (expire) begin
                  state  <= FS_DONE;
                  done_q <= 1'b1;
                  pass_q <= eng_pass;
               end
            end
            FS_DONE: begin
               if (ctl_wr && !ctl_hv) state <= ctl_mode ? FS_WAIT_IL : FS_IDLE;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   assign st_mode   = (state != FS_IDLE);
   assign st_hv     = (state == FS_PROG) || (state == FS_DONE);
   assign st_armed  = (state == FS_LOADED) || (state == FS_PROG) || (state == FS_DONE);
   assign st_done   = done_q;
   assign st_pass   = pass_q;
   assign st_shadow = shadow_q;

   // R6: the engine is only entered from the armed state
   a_r6_start_needs_interlock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_hv) |-> ($past(state) == FS_LOADED));

   // R9: done only falls on a start write
   a_r9_done_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_done) |-> $past(ctl_wr && ctl_hv));

   // R11: an unsuspended clear of high voltage aborts with a fail verdict
   a_r11_abort_result: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == FS_PROG) && ctl_wr && !ctl_hv && !prog_susp)
         |=> (st_done && !st_pass && !st_hv && st_mode));

   // R12: no exit from programming while suspended
   a_r12_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == FS_PROG) && prog_susp) |=> (state == FS_PROG));

   // R13: space status kept across an erase-suspended interlock
   a_r13_space_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == FS_WAIT_IL) && erase_susp) |=> $stable(st_shadow));

   // R8: a locked interlock leaves the block waiting
   a_r8_locked_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == FS_WAIT_IL) && arr_wr && blk_locked && !ctl_wr)
         |=> (state == FS_WAIT_IL));

   // R14: program mode cannot drop during programming
   a_r14_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_PROG) |=> st_mode);

endmodule

// File: tb/tb_flash_page_prog.sv
module tb_flash_page_prog;

   localparam int CLK_PERIOD = 10;
   localparam int P          = 8;
   localparam int AW         = 5;
   localparam int NWORDS     = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0, ctl_mode = 1'b0, ctl_hv = 1'b0;
   logic        arr_wr = 1'b0, arr_dw = 1'b0;
   logic [AW-1:0] arr_addr = '0;
   logic [63:0] arr_wdata = '0;
   logic [2:0]  lock_mask = '0;
   logic        prog_susp = 1'b0, erase_susp = 1'b0, eng_pass = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic        st_mode, st_hv, st_done, st_pass, st_armed, st_shadow;
   logic [31:0] rd_data;
   logic        rd_valid;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [31:0] exp_mem [NWORDS];
   logic        exp_vld [NWORDS];
   logic [31:0] bbuf [4];
   int          bsp, bpg;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_page_prog #(
      .PROG_CYCLES (P)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .ctl_wr (ctl_wr), .ctl_mode (ctl_mode), .ctl_hv (ctl_hv),
      .arr_wr (arr_wr), .arr_dw (arr_dw), .arr_addr (arr_addr), .arr_wdata (arr_wdata),
      .lock_mask (lock_mask), .prog_susp (prog_susp), .erase_susp (erase_susp),
      .eng_pass (eng_pass), .rd_addr (rd_addr),
      .st_mode (st_mode), .st_hv (st_hv), .st_done (st_done), .st_pass (st_pass),
      .st_armed (st_armed), .st_shadow (st_shadow),
      .rd_data (rd_data), .rd_valid (rd_valid)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int widx(input int sp, input int pg, input int w);
      return sp * 16 + pg * 4 + w;
   endfunction

   function automatic logic [31:0] pat(input int sp, input int pg, input int w, input int seed);
      return 32'h5A00_0000 ^ {8'(seed), 8'(sp), 8'(pg), 8'(w)};
   endfunction

   task automatic ctl_write(input bit m, input bit h);
      ctl_wr = 1'b1; ctl_mode = m; ctl_hv = h;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic ld(input int sp, input int pg, input int w, input bit dw,
                     input logic [63:0] data, input bit acc);
      arr_wr = 1'b1; arr_dw = dw; arr_addr = AW'(widx(sp, pg, w)); arr_wdata = data;
      @(negedge clk);
      arr_wr = 1'b0; arr_dw = 1'b0;
      if (acc) begin
         bsp = sp; bpg = pg;
         bbuf[w] = data[31:0];
         if (dw) bbuf[w + 1] = data[63:32];
      end
   endtask

   task automatic bclear();
      for (int i = 0; i < 4; i++) bbuf[i] = 32'hFFFF_FFFF;
   endtask

   task automatic check_mem(input string req);
      int errs = 0;
      for (int a = 0; a < NWORDS; a++) begin
         rd_addr = AW'(a);
         #1;
         if (rd_valid !== exp_vld[a] || (exp_vld[a] && rd_data !== exp_mem[a])) errs++;
      end
      chk(req, "array word mismatches", errs, 0);
      @(negedge clk);
   endtask

   // start programming and follow done to completion
   task automatic run_prog(input bit ok);
      eng_pass = ok;
      ctl_write(1'b1, 1'b1);
      chk("R9", "done cleared by start", st_done, 0);
      chk("R9", "hv set by start", st_hv, 1);
      repeat (P - 1) @(negedge clk);
      chk("R9", "done one edge early", st_done, 0);
      @(negedge clk);
      chk("R9", "done at count end", st_done, 1);
      chk("R9", "pass follows engine", st_pass, ok);
      for (int w = 0; w < 4; w++) begin
         exp_vld[widx(bsp, bpg, w)] = ok;
         if (ok) exp_mem[widx(bsp, bpg, w)] = bbuf[w];
      end
      check_mem("R9");
   endtask

   task automatic release_hv(input bit ok);
      ctl_write(1'b1, 1'b0);
      chk("R10", "hv cleared", st_hv, 0);
      chk("R10", "mode kept", st_mode, 1);
      chk("R10", "armed dropped", st_armed, 0);
      chk("R10", "done kept", st_done, 1);
      chk("R10", "pass kept", st_pass, ok);
      bclear();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < NWORDS; a++) begin
         exp_mem[a] = 32'hFFFF_FFFF;
         exp_vld[a] = 1'b1;
      end
      bclear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "mode", st_mode, 0);
      chk("R1", "hv", st_hv, 0);
      chk("R1", "done", st_done, 1);
      chk("R1", "pass", st_pass, 0);
      chk("R1", "armed", st_armed, 0);
      chk("R1", "shadow", st_shadow, 0);
      check_mem("R1");

      // R2 writes while idle are ignored; mode arms the interlock
      ld(0, 0, 0, 1'b0, 64'h1234, 1'b0);
      ctl_write(1'b1, 1'b0);
      chk("R2", "mode on", st_mode, 1);
      chk("R2", "idle write did not arm", st_armed, 0);

      // R6 start without an interlock is ignored
      ctl_write(1'b1, 1'b1);
      chk("R6", "hv stays low", st_hv, 0);
      chk("R6", "done unchanged", st_done, 1);

      // sweep over both spaces and every page
      for (int sp = 0; sp < 2; sp++) begin
         for (int pg = 0; pg < 4; pg++) begin
            int seed = sp * 4 + pg + 1;
            if (pg % 2 == 0) begin
               ld(sp, pg, 0, 1'b1, {pat(sp, pg, 1, seed), pat(sp, pg, 0, seed)}, 1'b1);
            end else begin
               ld(sp, pg, 3, 1'b0, {32'h0, pat(sp, pg, 3, seed)}, 1'b1);
               ld(sp, pg, 0, 1'b1, {pat(sp, pg, 1, seed), pat(sp, pg, 0, seed)}, 1'b1);
            end
            chk("R2", "interlock arms", st_armed, 1);
            chk("R13", "space status follows interlock", st_shadow, sp);
            ld(sp, pg, 2, 1'b0, {32'h0, 32'hDEAD_BEEF}, 1'b1);
            ld(sp, pg, 2, 1'b0, {32'h0, pat(sp, pg, 2, seed)}, 1'b1);
            run_prog(1'b1);
            release_hv(1'b1);
         end
      end

      // R5 other page ignored; R4 odd doubleword ignored; R3 unwritten erased
      ld(0, 1, 1, 1'b0, {32'h0, 32'hCAFE_0001}, 1'b1);
      ld(0, 2, 0, 1'b0, {32'h0, 32'hBAD0_0002}, 1'b0);
      ld(1, 1, 1, 1'b0, {32'h0, 32'hBAD0_0003}, 1'b0);
      ld(0, 1, 1, 1'b1, {32'hBAD0_0005, 32'hBAD0_0004}, 1'b0);
      run_prog(1'b1);
      chk("R3", "unwritten word reads erased",
          exp_mem[widx(0, 1, 3)], 32'hFFFF_FFFF);
      release_hv(1'b1);

      // R8 lock by block and shadow
      lock_mask = 3'b001;
      ld(0, 1, 0, 1'b0, {32'h0, 32'h1111_0000}, 1'b0);
      chk("R8", "locked block 0 page 1", st_armed, 0);
      ld(0, 2, 0, 1'b0, {32'h0, 32'h2222_0000}, 1'b1);
      chk("R8", "unlocked block 1 page 2", st_armed, 1);
      run_prog(1'b1);
      release_hv(1'b1);
      lock_mask = 3'b100;
      ld(1, 3, 0, 1'b0, {32'h0, 32'h3333_0000}, 1'b0);
      chk("R8", "locked shadow space", st_armed, 0);
      ld(0, 0, 1, 1'b0, {32'h0, 32'h4444_0000}, 1'b1);
      chk("R8", "normal page open", st_armed, 1);

      // R7 terminate before start
      ctl_write(1'b0, 1'b0);
      chk("R7", "mode off", st_mode, 0);
      chk("R7", "armed off", st_armed, 0);
      check_mem("R7");
      lock_mask = 3'b000;
      bclear();

      // R13 erase-suspended interlock keeps space status (currently 0)
      ctl_write(1'b1, 1'b0);
      erase_susp = 1'b1;
      ld(1, 1, 2, 1'b0, {32'h0, 32'h5555_0000}, 1'b1);
      chk("R13", "status kept under erase suspend", st_shadow, 0);
      erase_susp = 1'b0;
      run_prog(1'b1);
      release_hv(1'b1);

      // R11 abort
      ld(0, 3, 0, 1'b0, {32'h0, 32'h6666_0000}, 1'b1);
      ctl_write(1'b1, 1'b1);
      repeat (3) @(negedge clk);
      ctl_write(1'b1, 1'b0);
      chk("R11", "done after abort", st_done, 1);
      chk("R11", "pass low after abort", st_pass, 0);
      chk("R11", "hv low after abort", st_hv, 0);
      chk("R11", "armed low after abort", st_armed, 0);
      chk("R11", "mode kept after abort", st_mode, 1);
      for (int w = 0; w < 4; w++) exp_vld[widx(0, 3, w)] = 1'b0;
      check_mem("R11");
      bclear();

      // R12 suspend blocks abort and holds count; R14 mode ignored
      ld(1, 0, 2, 1'b0, {32'h0, 32'h7777_0000}, 1'b1);
      eng_pass = 1'b1;
      ctl_write(1'b1, 1'b1);
      repeat (2) @(negedge clk);
      prog_susp = 1'b1;
      ctl_write(1'b1, 1'b0);
      chk("R12", "hv kept under suspend", st_hv, 1);
      chk("R12", "done low under suspend", st_done, 0);
      ctl_write(1'b0, 1'b1);
      chk("R14", "mode kept while programming", st_mode, 1);
      repeat (4) @(negedge clk);
      chk("R12", "count held", st_done, 0);
      prog_susp = 1'b0;
      repeat (P - 3) @(negedge clk);
      chk("R12", "done one edge early after resume", st_done, 0);
      @(negedge clk);
      chk("R12", "done after resume", st_done, 1);
      chk("R12", "pass after resume", st_pass, 1);
      for (int w = 0; w < 4; w++) begin
         exp_vld[widx(1, 0, w)] = 1'b1;
         exp_mem[widx(1, 0, w)] = bbuf[w];
      end
      check_mem("R12");
      release_hv(1'b1);

      // R9 engine failure marks page invalid
      ld(0, 1, 0, 1'b0, {32'h0, 32'h8888_0000}, 1'b1);
      run_prog(1'b0);
      release_hv(1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule